// File: doc/BRIEF.md
# Two-Button Combination Lock Controller

This block is a synchronous Moore state machine for a locker keypad that has two buttons. On each clock it samples the two buttons as a two-bit combination. A button reads 1 while it is pressed or held and 0 when it is released. The machine compares the order of the combinations it sees with a stored code. The code includes an explicit all-released step between presses. When the whole code has been entered, the machine raises an unlock flag. When a combination breaks the code, it raises an alarm flag.

Only a change of combination counts as a step. A combination held across many clocks is one step, so the machine does not depend on how long a button is held. The first sample after reset always counts as a step. Unlock and alarm are both terminal: neither is left until reset. The state lives in a small Gray-coded register, and both outputs are decoded from that register alone. Debouncing, the latch driver and any timeout are outside the block.

Top module: `combo_lock_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to its start state. After that edge, `unlock` and `alarm` are both 0 and the machine waits for the first code step.
- R2: A sampled combination `{btnA,btnB}` is a step only if it differs from the sample taken at the previous edge, or if it is the first sample after reset. A combination held over several edges leaves the state, and so both outputs, unchanged.
- R3: The default code is the sequence 00, 10, 00, 01, 00, written as `{btnA,btnB}`. When its last step is sampled at an edge, `unlock` reads 1 after that edge.
- R4: A step that does not equal the next expected code combination moves the machine to the alarm state, and `alarm` reads 1 after that edge. This includes a first step that is not 00 and a step of 11.
- R5: Once `unlock` is 1, it stays 1 and `alarm` stays 0 whatever the buttons do, until reset.
- R6: Once `alarm` is 1, it stays 1 and `unlock` stays 0 whatever the buttons do, until reset.
- R7: `unlock` and `alarm` are never 1 at the same time.
- R8: The outputs depend only on the state. A change on `btnA` or `btnB` between clock edges does not change `unlock` or `alarm` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| btnA | input | 1 | First button, 1 while pressed or held |
| btnB | input | 1 | Second button, 1 while pressed or held |
| unlock | output | 1 | 1 once the full code has been entered |
| alarm | output | 1 | 1 once a wrong step has been seen |

## Verification
The bench builds the block with its default parameters: a five-step code of two-bit combinations, held in a three-bit Gray state register. These values bring every reachable state within reach: the start state, each partial-progress state, the open state and the alarm state. Random episodes are biased toward the correct next step, so runs reach deep into the code before they break it. Holds of varied length test the change-only stepping. Directed runs cover a wrong first step, a step of 11 and a break in the middle of the code.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int BTN_W = 2;

  typedef logic [BTN_W-1:0] combo_t;

  // strobes from the sampling datapath to the control
  typedef struct packed {
    logic evt;   // a new combination was sampled this cycle
    logic hit;   // the new combination equals the expected code step
  } keyStrobe_t;
endpackage

// File: rtl/lock_sampler.sv
module lock_sampler
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 5,
  parameter logic [CODE_LEN*BTN_W-1:0] CODE = {2'b00, 2'b01, 2'b00, 2'b10, 2'b00},
  parameter int ST_W = $clog2(CODE_LEN + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  combo_t          keys,
  input  logic [ST_W-1:0] stepIdx,
  output keyStrobe_t      strobe
);
  combo_t prevQ;
  logic   validQ;
  combo_t expected;
  logic   inCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ  <= '0;
      validQ <= 1'b0;
    end else begin
      prevQ  <= keys;
      validQ <= 1'b1;
    end
  end

  // pick the expected combination for the current progress index
  always_comb begin
    expected = '0;
    inCode   = 1'b0;
    for (int i = 0; i < CODE_LEN; i++) begin
      if (stepIdx == ST_W'(i)) begin
        expected = CODE[i*BTN_W +: BTN_W];
        inCode   = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.evt = !validQ || (keys != prevQ);
    strobe.hit = strobe.evt && inCode && (keys == expected);
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 5,
  parameter int ST_W = $clog2(CODE_LEN + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  keyStrobe_t      strobe,
  output logic [ST_W-1:0] stepIdx,
  output logic            unlock,
  output logic            alarm
);
  localparam logic [ST_W-1:0] OPEN_IDX  = ST_W'(CODE_LEN);
  localparam logic [ST_W-1:0] ALARM_IDX = ST_W'(CODE_LEN + 1);

  logic [ST_W-1:0] stateQ;   // Gray-coded progress
  logic [ST_W-1:0] stateD;
  logic [ST_W-1:0] idxNow;
  logic [ST_W-1:0] idxNext;

  // Gray to binary
  always_comb begin
    for (int i = 0; i < ST_W; i++) begin
      idxNow[i] = ^(stateQ >> i);
    end
  end

  always_comb begin
    idxNext = idxNow;
    if (idxNow > ALARM_IDX) begin
      idxNext = ALARM_IDX;                 // unused code, fall to safe state
    end else if (idxNow != OPEN_IDX && idxNow != ALARM_IDX && strobe.evt) begin
      idxNext = strobe.hit ? idxNow + 1'b1 : ALARM_IDX;
    end
    stateD = idxNext ^ (idxNext >> 1);     // binary to Gray
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= '0;
    else     stateQ <= stateD;
  end

  assign stepIdx = idxNow;
  assign unlock  = (idxNow == OPEN_IDX);
  assign alarm   = (idxNow == ALARM_IDX);
endmodule

// File: rtl/combo_lock_top.sv
module combo_lock_top
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 5,
  parameter logic [CODE_LEN*BTN_W-1:0] CODE = {2'b00, 2'b01, 2'b00, 2'b10, 2'b00}
) (
  input  logic clk,
  input  logic rst,
  input  logic btnA,
  input  logic btnB,
  output logic unlock,
  output logic alarm
);
  localparam int ST_W = $clog2(CODE_LEN + 2);

  keyStrobe_t      strobe;
  logic [ST_W-1:0] stepIdx;
  combo_t          keys;

  assign keys = {btnA, btnB};

  lock_sampler #(.CODE_LEN(CODE_LEN), .CODE(CODE), .ST_W(ST_W)) i_sampler (
    .clk(clk), .rst(rst), .keys(keys), .stepIdx(stepIdx), .strobe(strobe)
  );

  lock_ctrl #(.CODE_LEN(CODE_LEN), .ST_W(ST_W)) i_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .stepIdx(stepIdx),
    .unlock(unlock), .alarm(alarm)
  );
endmodule

// File: rtl/lock_checker.sv
module lock_checker (
  input logic clk,
  input logic rst,
  input logic btnA,
  input logic btnB,
  input logic unlock,
  input logic alarm
);
  // R1: reset clears both flags
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (!unlock && !alarm));

  // R7: flags are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst) !(unlock && alarm));

  // R5: open is absorbing
  a_r5_open_sticky: assert property (@(posedge clk) disable iff (rst) unlock |=> unlock);

  // R6: alarm is absorbing
  a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (rst) alarm |=> alarm);

  // R2: a repeated sample leaves the outputs unchanged
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && {btnA, btnB} == $past({btnA, btnB})) |=> $stable({unlock, alarm}));

  // R3: unlocking follows a sampled all-released step
  a_r3_open_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> ($past({btnA, btnB}) == 2'b00));
endmodule

bind combo_lock_top lock_checker i_lock_checker (
  .clk(clk), .rst(rst), .btnA(btnA), .btnB(btnB), .unlock(unlock), .alarm(alarm)
);

// File: tb/test_combo_lock_top.sv
module test_combo_lock_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnA = 1'b0;
  logic btnB = 1'b0;
  logic unlock, alarm;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [1:0] seq [5] = '{2'b00, 2'b10, 2'b00, 2'b01, 2'b00};
  logic [1:0] mPrev;
  logic       mValid;
  int         mPos;
  logic       mOpen, mAlarm;

  combo_lock_top i_combo_lock_top (
    .clk(clk), .rst(rst), .btnA(btnA), .btnB(btnB), .unlock(unlock), .alarm(alarm)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
    end
  endtask

  function automatic void modelStep(input logic [1:0] c);
    logic evt;
    evt = !mValid || (c != mPrev);
    mPrev  = c;
    mValid = 1'b1;
    if (!mOpen && !mAlarm && evt) begin
      if (c == seq[mPos]) begin
        mPos++;
        if (mPos == 5) mOpen = 1'b1;
      end else begin
        mAlarm = 1'b1;
      end
    end
  endfunction

  function automatic string tagNow();
    if (mOpen)  return "R5";
    if (mAlarm) return "R6";
    return "R2";
  endfunction

  // called at a negedge
  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mValid = 1'b0; mPos = 0; mOpen = 1'b0; mAlarm = 1'b0; mPrev = 2'b00;
    chk("R1", "unlock after reset", unlock, 1'b0);
    chk("R1", "alarm after reset", alarm, 1'b0);
  endtask

  // drive at a negedge, step the model, check at the next negedge
  task automatic apply(input logic [1:0] c, input string tag);
    {btnA, btnB} = c;
    modelStep(c);
    @(negedge clk);
    chk(tag, "unlock", unlock, mOpen);
    chk(tag, "alarm", alarm, mAlarm);
    chk("R7", "exclusive", unlock && alarm, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] c;
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    doReset();

    // R3 with holds of varied length (R2)
    apply(2'b00, "R2"); apply(2'b00, "R2");
    apply(2'b10, "R2"); apply(2'b10, "R2"); apply(2'b10, "R2");
    apply(2'b00, "R2");
    apply(2'b01, "R2"); apply(2'b01, "R2");
    // R8: final step driven, outputs unchanged before the edge
    {btnA, btnB} = 2'b00;
    #1;
    chk("R8", "unlock before edge", unlock, 1'b0);
    {btnA, btnB} = 2'b01;
    @(negedge clk);
    apply(2'b00, "R3");
    chk("R3", "unlock after code", unlock, 1'b1);
    for (int i = 0; i < 20; i++) apply(2'($urandom_range(0, 3)), "R5");
    chk("R5", "unlock still set", unlock, 1'b1);

    // R4: wrong first step
    doReset();
    apply(2'b11, "R4");
    chk("R4", "alarm on wrong first", alarm, 1'b1);
    for (int i = 0; i < 20; i++) apply(2'($urandom_range(0, 3)), "R6");

    // R4: 11 in the middle
    doReset();
    apply(2'b00, "R4"); apply(2'b10, "R4"); apply(2'b11, "R4");
    chk("R4", "alarm on 11", alarm, 1'b1);
    // R6: the full code after an alarm does not unlock
    apply(2'b00, "R6"); apply(2'b10, "R6"); apply(2'b00, "R6");
    apply(2'b01, "R6"); apply(2'b00, "R6");
    chk("R6", "no unlock after alarm", unlock, 1'b0);

    // R4: wrong order
    doReset();
    apply(2'b00, "R4"); apply(2'b01, "R4");
    chk("R4", "alarm on wrong order", alarm, 1'b1);

    // R1: reset clears an alarm
    doReset();
    chk("R1", "alarm cleared", alarm, 1'b0);

    // random episodes, biased toward the correct next step
    for (int e = 0; e < 400; e++) begin
      doReset();
      for (int k = 0; k < 14; k++) begin
        if (!mOpen && !mAlarm && $urandom_range(0, 9) < 7 && mPos < 5)
          c = seq[mPos];
        else if ($urandom_range(0, 3) == 0)
          c = mPrev;
        else
          c = 2'($urandom_range(0, 3));
        apply(c, tagNow());
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule